// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of a multiplexed external memory bus: an active-high address latch pulse (`ale`) and an active-low code read strobe (`psen_n`). It runs from the oscillator clock and divides it into machine cycles of twelve clocks. Each machine cycle has two six-clock halves, and each half holds one strobe slot of each kind. At the end of every machine cycle the block takes in a description of the next cycle: the kind of access, whether a table read or external data transfer instruction is in progress, and whether the core executes from external memory.

The address latch pulse runs at a steady one-sixth of the oscillator rate. An external data cycle drops the pulse of its second half. Code read strobes appear only in cycles that fetch from external memory, and none appear in an external data cycle. A one-bit configuration register can silence the latch pulse when it is not needed. While it is silenced the block flags that the pin should be held only weakly high. A table read, an external data transfer or external execution overrides that setting.

Top module: `strobe_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `ale`=0, `psen_n`=1, `ale_weak`=0, and the machine cycle restarts at phase 0 on the first edge with `rst` low.
- R2: Phases are numbered 0 to 11 within a machine cycle, counted from reset release. The outputs after the edge that closes phase p reflect phase p. When the latch pulse is enabled, `ale` is 1 for p mod 6 in {0,1}, which gives two 2-clock pulses per 12 clocks, and 0 elsewhere.
- R3: In a cycle with `acc_kind`=2 (external data), `ale` stays 0 for phases 6 to 11 and still pulses at phases 0 and 1.
- R4: In a cycle with `acc_kind`=1 (external code fetch), `psen_n` is 0 for p mod 6 in {3,4} and 1 elsewhere.
- R5: In a cycle with `acc_kind`=0 (internal fetch) or 3 (treated as internal), `psen_n` stays 1.
- R6: In a cycle with `acc_kind`=2, `psen_n` stays 1 for all twelve phases.
- R7: When the disable bit is 1 and neither `xmem_op` nor `ext_exec` is set for the cycle, `ale` stays 0 and `ale_weak` is 1. Otherwise `ale_weak` is 0.
- R8: With `ext_exec`=1 or `xmem_op`=1 for the cycle, the disable bit has no effect on `ale` and `ale_weak`.
- R9: `acc_kind`, `xmem_op` and `ext_exec` are sampled only at the edge that closes phase 11 and apply to the next twelve phases. Changes at other edges have no effect.
- R10: The disable bit is `cfg_wdata[0]`, written when `cfg_we`=1. It resets to 0 and takes effect from the phase after the write edge. Other bits of `cfg_wdata`, and `cfg_wdata` with `cfg_we`=0, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | Next cycle's access: 0 internal, 1 external code, 2 external data, 3 internal |
| xmem_op | input | 1 | Next cycle belongs to a table read or external data transfer instruction |
| ext_exec | input | 1 | Next cycle executes from external memory |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data; bit 0 is the latch-pulse disable |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code read strobe, active low |
| ale_weak | output | 1 | Latch pin should be held only weakly high |

## Verification
All 24 combinations of access kind, instruction flag, execution flag and disable bit are swept, one machine cycle each, and every output is compared at every phase. This separates the per-half data skip (ALE missing only in the second half) from a global disable (both halves missing with the weak flag set). It also shows that each of the two override inputs lifts the disable by itself. Between sampling edges the cycle inputs and the unwritten configuration data are scrambled, so sampling at the wrong edge shows up as a wrong strobe. A final reset after the disable bit has been set shows that the phase restarts and the bit clears.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef enum logic [1:0] {
    ACC_INT  = 2'd0,
    ACC_CODE = 2'd1,
    ACC_DATA = 2'd2,
    ACC_RSVD = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    logic      xmem;
    logic      ext;
  } cyc_info_t;

  localparam cyc_info_t CYC_IDLE = '{kind: ACC_INT, xmem: 1'b0, ext: 1'b0};

endpackage

// File: rtl/strobe_phase_ctr.sv
module strobe_phase_ctr #(
  parameter int HALF_CLKS = 6,
  parameter int HALVES    = 2,
  localparam int SLOT_W   = $clog2(HALF_CLKS),
  localparam int HALF_W   = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot,
  output logic [HALF_W-1:0] half,
  output logic              cycle_end
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(HALF_CLKS - 1);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALVES - 1);

  logic slot_wrap;
  assign slot_wrap = (slot == SLOT_LAST);
  assign cycle_end = slot_wrap && (half == HALF_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      half <= '0;
    end else begin
      slot <= slot_wrap ? '0 : slot + 1'b1;
      if (slot_wrap) half <= (half == HALF_LAST) ? '0 : half + 1'b1;
    end
  end

  // R2: a half always advances only after its last slot
  assert_half_step_R2: assert property (@(posedge clk) disable iff (rst)
    !slot_wrap |=> $stable(half));

endmodule

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg #(
  parameter int CFG_W   = 8,
  parameter int DIS_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic             ale_dis
);

  always_ff @(posedge clk) begin
    if (rst)     ale_dis <= 1'b0;
    else if (we) ale_dis <= wdata[DIS_BIT];
  end

  assert_dis_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ale_dis);

  assert_dis_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ale_dis));

endmodule

// File: rtl/strobe_cycle_latch.sv
module strobe_cycle_latch
  import strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cycle_end,
  input  cyc_info_t nxt,
  output cyc_info_t cur
);

  always_ff @(posedge clk) begin
    if (rst)            cur <= CYC_IDLE;
    else if (cycle_end) cur <= nxt;
  end

  assert_cycle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(cur));

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import strobe_pkg::*;
#(
  parameter int HALF_CLKS  = 6,
  parameter int PULSE_CLKS = 2,
  parameter int PSEN_START = 3,
  parameter int CFG_W      = 8,
  parameter int DIS_BIT    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       acc_kind,
  input  logic             xmem_op,
  input  logic             ext_exec,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             ale,
  output logic             psen_n,
  output logic             ale_weak
);

  localparam int HALVES = 2;
  localparam int SLOT_W = $clog2(HALF_CLKS);
  localparam int HALF_W = $clog2(HALVES);
  localparam logic [SLOT_W-1:0] ALE_END  = SLOT_W'(PULSE_CLKS);
  localparam logic [SLOT_W-1:0] PSEN_BEG = SLOT_W'(PSEN_START);
  localparam logic [SLOT_W-1:0] PSEN_END = SLOT_W'(PSEN_START + PULSE_CLKS);

  logic [SLOT_W-1:0] slot;
  logic [HALF_W-1:0] half;
  logic              cycle_end;
  logic              ale_dis;
  cyc_info_t         nxt, cur;

  strobe_phase_ctr #(.HALF_CLKS(HALF_CLKS), .HALVES(HALVES)) u_phase (
    .clk(clk), .rst(rst), .slot(slot), .half(half), .cycle_end(cycle_end)
  );

  strobe_cfg_reg #(.CFG_W(CFG_W), .DIS_BIT(DIS_BIT)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .ale_dis(ale_dis)
  );

  assign nxt = '{kind: acc_kind_e'(acc_kind), xmem: xmem_op, ext: ext_exec};

  strobe_cycle_latch u_latch (
    .clk(clk), .rst(rst), .cycle_end(cycle_end), .nxt(nxt), .cur(cur)
  );

  // Per-half strobe permission: the data cycle gives up its second address
  // pulse and both code strobes.
  logic [HALVES-1:0] half_ale_ok, half_psen_ok;
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_ale_ok[h]  = !((cur.kind == ACC_DATA) && (h == HALVES - 1));
    assign half_psen_ok[h] = (cur.kind == ACC_CODE);
  end

  logic ale_en, ale_slot, psen_slot, ale_d, psen_d;
  always_comb begin
    ale_en    = !ale_dis || cur.ext || cur.xmem;
    ale_slot  = (slot < ALE_END);
    psen_slot = (slot >= PSEN_BEG) && (slot < PSEN_END);
    ale_d     = ale_en && ale_slot && half_ale_ok[half];
    psen_d    = psen_slot && half_psen_ok[half];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale      <= 1'b0;
      psen_n   <= 1'b1;
      ale_weak <= 1'b0;
    end else begin
      ale      <= ale_d;
      psen_n   <= !psen_d;
      ale_weak <= !ale_en;
    end
  end

  assert_data_skip_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(cur.kind) == ACC_DATA && $past(half) == HALF_W'(HALVES - 1)) |-> !ale);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  assert_int_no_psen_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cur.kind) == ACC_INT) |-> psen_n);

  assert_data_no_psen_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cur.kind) == ACC_DATA) |-> psen_n);

  assert_weak_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ale_weak |-> !ale);

  assert_ext_override_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(cur.ext) || $past(cur.xmem)) |-> !ale_weak);

endmodule

// File: tb/tb_strobe_gen.sv
module tb_strobe_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] acc_kind = 2'd0;
  logic       xmem_op = 1'b0;
  logic       ext_exec = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       ale, psen_n, ale_weak;

  int checks = 0;
  int errors = 0;
  int e = 0;               // edges since reset release
  logic [1:0] m_kind = 2'd0;
  logic m_xm = 1'b0, m_ex = 1'b0, m_dis = 1'b0;

  always #4 clk = ~clk;    // 125 MHz

  strobe_gen dut (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .xmem_op(xmem_op),
    .ext_exec(ext_exec), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ale(ale), .psen_n(psen_n), .ale_weak(ale_weak)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s edge=%0d phase=%0d kind=%0d xm=%0b ex=%0b dis=%0b: got %b expected %b",
               tag, what, e, (e + 11) % 12, m_kind, m_xm, m_ex, m_dis, got, exp);
    end
  endtask

  // Advance one clock and check outputs against the requirement model.
  task automatic step();
    logic r, w, wd, sx, se;
    logic [1:0] sk;
    int ph, s, h;
    logic en, exp_ale, exp_psen_n;
    r = rst; w = cfg_we; wd = cfg_wdata[0];
    sk = acc_kind; sx = xmem_op; se = ext_exec;
    @(posedge clk);
    @(negedge clk);
    if (r) begin
      chk("R1", "ale", ale, 1'b0);
      chk("R1", "psen_n", psen_n, 1'b1);
      chk("R1", "ale_weak", ale_weak, 1'b0);
      e = 0; m_kind = 2'd0; m_xm = 1'b0; m_ex = 1'b0; m_dis = 1'b0;
    end else begin
      e++;
      ph = (e - 1) % 12;
      s = ph % 6;
      h = ph / 6;
      en = !m_dis || m_xm || m_ex;
      exp_ale = en && (s < 2) && !(m_kind == 2'd2 && h == 1);
      exp_psen_n = !(m_kind == 2'd1 && (s == 3 || s == 4));
      if (m_dis && !(m_xm || m_ex)) chk("R7", "ale", ale, exp_ale);
      else if (m_dis)               chk("R8", "ale", ale, exp_ale);
      else if (m_kind == 2'd2)      chk("R3", "ale", ale, exp_ale);
      else                          chk("R2", "ale", ale, exp_ale);
      if (m_kind == 2'd1)      chk("R4", "psen_n", psen_n, exp_psen_n);
      else if (m_kind == 2'd2) chk("R6", "psen_n", psen_n, exp_psen_n);
      else                     chk("R5", "psen_n", psen_n, exp_psen_n);
      chk(m_dis ? "R8" : "R7", "ale_weak", ale_weak, !en);
      if (w) m_dis = wd;                     // R10: only bit 0 counts
      if (e % 12 == 0) begin                 // R9: sampled at cycle end only
        m_kind = sk; m_xm = sx; m_ex = se;
      end
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();                                  // R1 reset values
    step();
    rst = 1'b0;
    for (int k = 0; k < 11; k++) step();     // cycle 0 uses idle info (R2)
    for (int i = 0; i < 24; i++) begin
      acc_kind = 2'(i % 3);
      xmem_op  = 1'((i / 3) % 2);
      ext_exec = 1'((i / 6) % 2);
      cfg_we   = 1'b1;
      cfg_wdata = {7'($urandom), 1'((i / 12) % 2)};   // R10 upper bits junk
      step();
      cfg_we = 1'b0;
      for (int k = 0; k < 11; k++) begin
        // R9: scramble mid-cycle inputs and unwritten config data
        acc_kind  = 2'($urandom % 3);
        xmem_op   = 1'($urandom);
        ext_exec  = 1'($urandom);
        cfg_wdata = 8'($urandom);
        step();
      end
    end
    // R10/R1: set disable bit, then reset mid-run; bit must clear
    acc_kind = 2'd1; xmem_op = 1'b0; ext_exec = 1'b0;
    cfg_we = 1'b1; cfg_wdata = 8'h01;
    step();
    cfg_we = 1'b0; cfg_wdata = 8'h00;
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    for (int k = 0; k < 24; k++) step();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule